// File: doc/BRIEF.md
# Serial Character Receiver with Line-Error Reporting

This block turns an asynchronous serial line into parallel characters. A baud divider elsewhere supplies a one-cycle tick enable at sixteen times the bit rate, so every bit on the line spans sixteen ticks. The receiver passes the line through a synchroniser, watches for a falling edge and confirms it in the middle of the start bit. It then samples each data bit, the optional parity bit and the stop bit or bits at their centres.

Each completed character is offered to a downstream receive FIFO through a one-cycle write strobe with the data. Four error indications are raised in the same cycle: parity, framing, break and overrun. If the FIFO reports full when a character completes, the character is dropped and only the overrun indication and the line errors are raised. The character size, parity mode and stop-bit framing are inputs that software may change at any time. The receiver captures them when it confirms a start bit, so a change in the middle of a character has no effect on that character.

Top module: `serial_rx_deframer`

## Requirements
- R1: While reset is low, and in the first cycle after it, push_o, push_data_o and all four error outputs are zero.
- R2: A start is detected on a tick at which the synchronised line (two flops) is low. It is confirmed only if the line is still low on the 8th tick after detection. If the line is high there, the receiver returns to idle and nothing is pushed.
- R3: Data bits are sampled every 16 ticks after the start confirmation, least significant bit first. One cycle after the tick that samples the last stop bit, push_o is high for exactly one cycle and push_data_o carries the character.
- R4: cfg_size_i equal to 7 selects 7 data bits, and push_data_o[7] is then 0. Every other value selects 8 data bits.
- R5: cfg_parity_i equal to 1 selects odd parity and 2 selects even parity. In either mode one parity bit follows the data, and err_parity_o is raised with the character when the received bit is wrong. Values 0 and 3 mean that no parity bit is expected and err_parity_o stays 0.
- R6: err_frame_o is raised with the character when the first stop sample, taken 16 ticks after the last data or parity sample, is 0.
- R7: err_break_o is raised when all data bits and the first stop sample are 0. err_frame_o is always raised with it.
- R8: cfg_stop_i equal to 1 (one and a half stop bits) adds a second stop sample 12 ticks after the first. The value 2 (two stop bits) adds one 16 ticks after the first. The character completes at that second sample, and a 0 there raises err_frame_o. The value 3 behaves as one stop bit.
- R9: If fifo_full_i is high in the cycle in which a character completes, push_o stays low and err_overrun_o pulses instead. The parity, frame and break indications are still raised for that character.
- R10: The parity, size and stop settings are captured at start confirmation. Changing the inputs during a character does not alter how that character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_serial_i | input | 1 | Asynchronous serial line, idle high |
| baud_tick_i | input | 1 | One-cycle enable at 16 times the bit rate |
| cfg_parity_i | input | 2 | 0 none, 1 odd, 2 even, 3 treated as none |
| cfg_size_i | input | 4 | 7 gives seven data bits, any other value gives eight |
| cfg_stop_i | input | 2 | 0 one, 1 one and a half, 2 two, 3 treated as one |
| fifo_full_i | input | 1 | Receive FIFO cannot take a character |
| push_o | output | 1 | Write strobe into the receive FIFO |
| push_data_o | output | 8 | Character most recently completed |
| err_parity_o | output | 1 | Parity error pulse |
| err_frame_o | output | 1 | Framing error pulse |
| err_break_o | output | 1 | Break pulse |
| err_overrun_o | output | 1 | Overrun pulse (character dropped) |

## Verification
Overrun and the line errors can fall in the same cycle. The bench provokes this by holding fifo_full_i high while it sends a character whose stop bit is low. It expects err_overrun_o and err_frame_o together, with push_o staying low. A second collision comes from a low stop bit or a low second stop segment. That tail can look like a new start right after a character completes, and the bench expects the start check to reject it without an extra push. A behavioural model counts ticks from detection and is compared with every output on every clock. Per-scenario checks compare the pushed data and the error counts with the character that was sent.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_EXTRA
  } rx_state_e;

  localparam logic [1:0] PAR_ODD      = 2'd1;
  localparam logic [1:0] PAR_EVEN     = 2'd2;
  localparam logic [1:0] STP_ONE_HALF = 2'd1;
  localparam logic [1:0] STP_TWO      = 2'd2;
  localparam logic [3:0] SIZE_SHORT   = 4'd7;

  // parity bit is expected only for the two legal parity codes
  function automatic logic f_par_enabled(input logic [1:0] mode);
    return (mode == PAR_ODD) || (mode == PAR_EVEN);
  endfunction

  // a second stop sample is taken only for the two legal extended codes
  function automatic logic f_wants_extra(input logic [1:0] mode);
    return (mode == STP_ONE_HALF) || (mode == STP_TWO);
  endfunction

  // ticks from first stop sample to the second one
  function automatic int f_extra_ticks(input logic [1:0] mode, input int ovs);
    return (mode == STP_ONE_HALF) ? (ovs * 3) / 4 : ovs;
  endfunction

  // red is the xor of the received data bits
  function automatic logic f_par_wrong(input logic red, input logic pbit, input logic odd);
    return red ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/rxd_sync.sv
module rxd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[N-2:0], d_i};
  end

  assign q_o = chain_q[N-1];
endmodule

// File: rtl/rxd_framer.sv
module rxd_framer
  import rxd_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic [1:0]    par_mode_i,
  input  logic [3:0]    size_i,
  input  logic [1:0]    stop_mode_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          par_on_o,
  output logic          par_odd_o,
  output logic          par_bit_o,
  output logic          stop1_o,
  output logic          stop2_o,
  output logic          short_o
);
  localparam int CW = $clog2(OVS);
  localparam int IW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_LAST   = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID    = CW'(OVS / 2 - 1);
  localparam logic [IW-1:0] IDX_FULL   = IW'(DW - 1);
  localparam logic [IW-1:0] IDX_SHORT  = IW'(DW - 2);

  rx_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic [IW-1:0]   idx_q;
  logic [DW-1:0]   data_q;
  logic            pbit_q;
  logic            stop1_q;
  logic            par_on_q;
  logic            par_odd_q;
  logic            short_q;
  logic            extra_q;
  logic [CW-1:0]   extra_lim_q;

  // named events
  logic tick_end, start_chk, start_ok, start_bad, bit_smp, last_bit, stop_smp, extra_smp;

  assign tick_end  = tick_i && (cnt_q == CNT_LAST);
  assign start_chk = (state_q == RX_START) && tick_i && (cnt_q == CNT_MID);
  assign start_ok  = start_chk && !line_i;
  assign start_bad = start_chk && line_i;
  assign bit_smp   = (state_q == RX_DATA) && tick_end;
  assign last_bit  = (idx_q == (short_q ? IDX_SHORT : IDX_FULL));
  assign stop_smp  = (state_q == RX_STOP) && tick_end;
  assign extra_smp = (state_q == RX_EXTRA) && tick_i && (cnt_q == extra_lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      data_q      <= '0;
      pbit_q      <= 1'b0;
      stop1_q     <= 1'b1;
      par_on_q    <= 1'b0;
      par_odd_q   <= 1'b0;
      short_q     <= 1'b0;
      extra_q     <= 1'b0;
      extra_lim_q <= '0;
    end else begin
      if (tick_i && (state_q != RX_IDLE)) cnt_q <= cnt_q + 1'b1;
      case (state_q)
        RX_IDLE: begin
          if (tick_i && !line_i) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (start_bad) begin
            state_q <= RX_IDLE;
          end else if (start_ok) begin
            state_q     <= RX_DATA;
            cnt_q       <= '0;
            idx_q       <= '0;
            data_q      <= '0;
            par_on_q    <= f_par_enabled(par_mode_i);
            par_odd_q   <= (par_mode_i == PAR_ODD);
            short_q     <= (size_i == SIZE_SHORT);
            extra_q     <= f_wants_extra(stop_mode_i);
            extra_lim_q <= CW'(f_extra_ticks(stop_mode_i, OVS) - 1);
          end
        end
        RX_DATA: begin
          if (bit_smp) begin
            data_q[idx_q] <= line_i;
            idx_q         <= idx_q + 1'b1;
            if (last_bit) state_q <= par_on_q ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          if (tick_end) begin
            pbit_q  <= line_i;
            state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (stop_smp) begin
            stop1_q <= line_i;
            state_q <= extra_q ? RX_EXTRA : RX_IDLE;
          end
        end
        RX_EXTRA: begin
          if (extra_smp) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o    = (stop_smp && !extra_q) || extra_smp;
  assign data_o    = data_q;
  assign par_on_o  = par_on_q;
  assign par_odd_o = par_odd_q;
  assign par_bit_o = pbit_q;
  assign stop1_o   = stop_smp ? line_i : stop1_q;
  assign stop2_o   = extra_smp ? line_i : 1'b1;
  assign short_o   = short_q;

  // R2: entering the start check needs a low line at the detecting tick
  a_r2_start_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == RX_START) |-> $past(!line_i && tick_i));

  // R10: captured settings hold while a character is being received
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != RX_IDLE) && (state_q != RX_START) && $past(state_q != RX_START))
      |-> ($stable(par_on_q) && $stable(short_q) && $stable(extra_q)));

  // R8: the second stop sample is only reached when an extended stop was captured
  a_r8_extra_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    extra_smp |-> extra_q);
endmodule

// File: rtl/rxd_report.sv
module rxd_report
  import rxd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          par_on_i,
  input  logic          par_odd_i,
  input  logic          par_bit_i,
  input  logic          stop1_i,
  input  logic          stop2_i,
  input  logic          full_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          err_parity_o,
  output logic          err_frame_o,
  output logic          err_break_o,
  output logic          err_overrun_o
);
  logic perr_w, ferr_w, brk_w;

  assign perr_w = par_on_i && f_par_wrong(^data_i, par_bit_i, par_odd_i);
  assign ferr_w = !stop1_i || !stop2_i;
  assign brk_w  = (data_i == '0) && !stop1_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_o        <= 1'b0;
      push_data_o   <= '0;
      err_parity_o  <= 1'b0;
      err_frame_o   <= 1'b0;
      err_break_o   <= 1'b0;
      err_overrun_o <= 1'b0;
    end else begin
      push_o        <= done_i && !full_i;
      err_overrun_o <= done_i && full_i;
      err_parity_o  <= done_i && perr_w;
      err_frame_o   <= done_i && ferr_w;
      err_break_o   <= done_i && brk_w;
      if (done_i) push_data_o <= data_i;
    end
  end

  // R9: nothing is written while the FIFO was full
  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !$past(full_i));
  a_r9_push_or_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && err_overrun_o));
  // R7: a break is always also a framing error
  a_r7_break_is_frame: assert property (@(posedge clk) disable iff (!rst_n)
    err_break_o |-> err_frame_o);
  // R5: parity errors only with parity enabled
  a_r5_parity_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity_o |-> $past(par_on_i));
  // R3: the write strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o);
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import rxd_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_serial_i,
  input  logic          baud_tick_i,
  input  logic [1:0]    cfg_parity_i,
  input  logic [3:0]    cfg_size_i,
  input  logic [1:0]    cfg_stop_i,
  input  logic          fifo_full_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          err_parity_o,
  output logic          err_frame_o,
  output logic          err_break_o,
  output logic          err_overrun_o
);
  logic          line_w;
  logic          done_w;
  logic [DW-1:0] data_w;
  logic          par_on_w, par_odd_w, par_bit_w, stop1_w, stop2_w, short_w;

  rxd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_serial_i),
    .q_o   (line_w)
  );

  rxd_framer #(.OVS(OVS), .DW(DW)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (baud_tick_i),
    .line_i      (line_w),
    .par_mode_i  (cfg_parity_i),
    .size_i      (cfg_size_i),
    .stop_mode_i (cfg_stop_i),
    .done_o      (done_w),
    .data_o      (data_w),
    .par_on_o    (par_on_w),
    .par_odd_o   (par_odd_w),
    .par_bit_o   (par_bit_w),
    .stop1_o     (stop1_w),
    .stop2_o     (stop2_w),
    .short_o     (short_w)
  );

  rxd_report #(.DW(DW)) u_report (
    .clk           (clk),
    .rst_n         (rst_n),
    .done_i        (done_w),
    .data_i        (data_w),
    .par_on_i      (par_on_w),
    .par_odd_i     (par_odd_w),
    .par_bit_i     (par_bit_w),
    .stop1_i       (stop1_w),
    .stop2_i       (stop2_w),
    .full_i        (fifo_full_i),
    .push_o        (push_o),
    .push_data_o   (push_data_o),
    .err_parity_o  (err_parity_o),
    .err_frame_o   (err_frame_o),
    .err_break_o   (err_break_o),
    .err_overrun_o (err_overrun_o)
  );

  // R4: a short character never carries a top bit
  a_r4_short_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !(short_w && push_data_o[DW-1]));
  // R1: no event appears in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !(push_o || err_parity_o || err_frame_o || err_break_o || err_overrun_o));
endmodule

// File: tb/tb_serial_rx_deframer.sv
module tb_serial_rx_deframer;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic tick = 1'b0;
  logic [1:0] cfg_par = 2'd0;
  logic [3:0] cfg_size = 4'd8;
  logic [1:0] cfg_stop = 2'd0;
  logic full = 1'b0;

  logic       push_o, err_parity_o, err_frame_o, err_break_o, err_overrun_o;
  logic [7:0] push_data_o;

  serial_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .rx_serial_i(rxd), .baud_tick_i(tick),
    .cfg_parity_i(cfg_par), .cfg_size_i(cfg_size), .cfg_stop_i(cfg_stop),
    .fifo_full_i(full), .push_o(push_o), .push_data_o(push_data_o),
    .err_parity_o(err_parity_o), .err_frame_o(err_frame_o),
    .err_break_o(err_break_o), .err_overrun_o(err_overrun_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // baud tick generator
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == 0);
  end

  // reference model: counts ticks since the detecting tick
  logic m_s1 = 1'b1, m_s2 = 1'b1, ln;
  bit   m_act;
  int   m_n, nb, spos;
  bit   pon, podd;
  logic [1:0] sm;
  logic [7:0] m_d;
  logic m_pb, m_st1;
  logic e_push, e_pe, e_fe, e_bk, e_ov;
  logic [7:0] e_data;

  task automatic m_finish(input logic s1, input logic s2);
    logic red;
    red = ^m_d;
    e_pe   = pon && (red ^ m_pb ^ podd);
    e_fe   = !s1 || !s2;
    e_bk   = (m_d == 8'd0) && !s1;
    e_push = !full;
    e_ov   = full;
    e_data = m_d;
    m_act  = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_act = 0; m_n = 0;
      e_push = 0; e_pe = 0; e_fe = 0; e_bk = 0; e_ov = 0; e_data = 0;
    end else begin
      ln = m_s2; m_s2 = m_s1; m_s1 = rxd;
      e_push = 0; e_pe = 0; e_fe = 0; e_bk = 0; e_ov = 0;
      if (tick) begin
        if (!m_act) begin
          if (!ln) begin m_act = 1; m_n = 0; end
        end else begin
          m_n++;
          if (m_n == 8) begin
            if (ln) m_act = 0;
            else begin
              nb = (cfg_size == 4'd7) ? 7 : 8;
              pon = (cfg_par == 2'd1) || (cfg_par == 2'd2);
              podd = (cfg_par == 2'd1);
              sm = cfg_stop;
              m_d = 8'd0;
            end
          end else if (m_n > 8) begin
            int k, r;
            k = (m_n - 8) / 16;
            r = (m_n - 8) % 16;
            spos = 8 + 16 * (nb + 1 + (pon ? 1 : 0));
            if (r == 0 && k >= 1 && k <= nb) m_d[k-1] = ln;
            else if (r == 0 && pon && k == nb + 1) m_pb = ln;
            if (m_n == spos) begin
              m_st1 = ln;
              if (sm != 2'd1 && sm != 2'd2) m_finish(ln, 1'b1);
            end
            if (sm == 2'd1 && m_n == spos + 12) m_finish(m_st1, ln);
            if (sm == 2'd2 && m_n == spos + 16) m_finish(m_st1, ln);
          end
        end
      end
    end
  end

  // per-cycle comparison and event counters
  int c_push = 0, c_pe = 0, c_fe = 0, c_bk = 0, c_ov = 0;
  logic [7:0] last_data = 8'd0;
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      cmp("R3 push_o", push_o, e_push);
      cmp("R3 push_data_o", push_data_o, e_data);
      cmp("R5 err_parity_o", err_parity_o, e_pe);
      cmp("R6 err_frame_o", err_frame_o, e_fe);
      cmp("R7 err_break_o", err_break_o, e_bk);
      cmp("R9 err_overrun_o", err_overrun_o, e_ov);
      if (push_o) begin c_push++; last_data = push_data_o; end
      if (err_parity_o) c_pe++;
      if (err_frame_o) c_fe++;
      if (err_break_o) c_bk++;
      if (err_overrun_o) c_ov++;
    end
  end

  int k_push, k_pe, k_fe, k_bk, k_ov;
  task automatic mark;
    k_push = c_push; k_pe = c_pe; k_fe = c_fe; k_bk = c_bk; k_ov = c_ov;
  endtask

  task automatic expect_evt(input string req, input int pu, input logic [7:0] d,
                            input int pe, input int fe, input int bk, input int ov);
    cmp({req, " push count"}, c_push - k_push, pu);
    if (pu > 0) cmp({req, " data"}, last_data, d);
    cmp({req, " parity count"}, c_pe - k_pe, pe);
    cmp({req, " frame count"}, c_fe - k_fe, fe);
    cmp({req, " break count"}, c_bk - k_bk, bk);
    cmp({req, " overrun count"}, c_ov - k_ov, ov);
  endtask

  task automatic send_seq(input logic [15:0] v, input int n, input int last_ticks);
    for (int i = 0; i < n; i++) begin
      rxd = v[i];
      repeat (((i == n - 1) ? last_ticks : 16) * TDIV) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (48 * TDIV) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int nbits, input int pm,
                           input bit flip, input bit stp, input bit add_low,
                           input int last_ticks);
    logic [15:0] v;
    int n;
    logic pb;
    v = '0; n = 1; pb = 1'b0;
    for (int i = 0; i < nbits; i++) begin v[n] = d[i]; pb ^= d[i]; n++; end
    if (pm == 1 || pm == 2) begin
      if (pm == 1) pb = ~pb;
      v[n] = pb ^ flip; n++;
    end
    v[n] = stp; n++;
    if (add_low) begin v[n] = 1'b0; n++; end
    send_seq(v, n, last_ticks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    cmp("R1 push_o", push_o, 0);
    cmp("R1 push_data_o", push_data_o, 0);
    cmp("R1 errors", {err_parity_o, err_frame_o, err_break_o, err_overrun_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 push_o after release", push_o, 0);
    repeat (8 * TDIV) @(negedge clk);

    // R3 plain characters
    mark(); send_char(8'hA5, 8, 0, 0, 1, 0, 16); expect_evt("R3 A5", 1, 8'hA5, 0, 0, 0, 0);
    mark(); send_char(8'h01, 8, 0, 0, 1, 0, 16); expect_evt("R3 01", 1, 8'h01, 0, 0, 0, 0);

    // R4 character size
    cfg_size = 4'd7;
    mark(); send_char(8'h3C, 7, 0, 0, 1, 0, 16); expect_evt("R4 seven 3C", 1, 8'h3C, 0, 0, 0, 0);
    mark(); send_char(8'h7F, 7, 0, 0, 1, 0, 16); expect_evt("R4 seven 7F", 1, 8'h7F, 0, 0, 0, 0);
    cfg_size = 4'd5;
    mark(); send_char(8'h80, 8, 0, 0, 1, 0, 16); expect_evt("R4 other size", 1, 8'h80, 0, 0, 0, 0);
    cfg_size = 4'd8;

    // R5 parity
    cfg_par = 2'd1;
    mark(); send_char(8'h5A, 8, 1, 0, 1, 0, 16); expect_evt("R5 odd ok", 1, 8'h5A, 0, 0, 0, 0);
    mark(); send_char(8'h5B, 8, 1, 1, 1, 0, 16); expect_evt("R5 odd bad", 1, 8'h5B, 1, 0, 0, 0);
    cfg_par = 2'd2;
    mark(); send_char(8'h96, 8, 2, 1, 1, 0, 16); expect_evt("R5 even bad", 1, 8'h96, 1, 0, 0, 0);
    mark(); send_char(8'h97, 8, 2, 0, 1, 0, 16); expect_evt("R5 even ok", 1, 8'h97, 0, 0, 0, 0);
    cfg_par = 2'd3;
    mark(); send_char(8'h81, 8, 0, 0, 1, 0, 16); expect_evt("R5 code 3 none", 1, 8'h81, 0, 0, 0, 0);
    cfg_par = 2'd0;

    // R6 framing, R7 break
    mark(); send_char(8'h42, 8, 0, 0, 0, 0, 10); expect_evt("R6 low stop", 1, 8'h42, 0, 1, 0, 0);
    mark(); send_char(8'h00, 8, 0, 0, 0, 0, 10); expect_evt("R7 break", 1, 8'h00, 0, 1, 1, 0);

    // R8 stop framing
    cfg_stop = 2'd1;
    mark(); send_char(8'h33, 8, 0, 0, 1, 1, 8); expect_evt("R8 half low", 1, 8'h33, 0, 1, 0, 0);
    mark(); send_char(8'h34, 8, 0, 0, 1, 0, 16); expect_evt("R8 half ok", 1, 8'h34, 0, 0, 0, 0);
    cfg_stop = 2'd2;
    mark(); send_char(8'h35, 8, 0, 0, 1, 0, 16); expect_evt("R8 two ok", 1, 8'h35, 0, 0, 0, 0);
    mark(); send_char(8'h36, 8, 0, 0, 1, 1, 10); expect_evt("R8 two low", 1, 8'h36, 0, 1, 0, 0);
    cfg_stop = 2'd3;
    mark(); send_char(8'h44, 8, 0, 0, 1, 0, 16); expect_evt("R8 code 3 one", 1, 8'h44, 0, 0, 0, 0);
    cfg_stop = 2'd0;

    // R9 overrun together with a framing error
    full = 1'b1;
    mark(); send_char(8'h77, 8, 0, 0, 0, 0, 10); expect_evt("R9 overrun", 0, 8'h00, 0, 1, 0, 1);
    full = 1'b0;

    // R2 short low pulse is rejected
    mark(); send_seq(16'h0000, 1, 4); expect_evt("R2 glitch", 0, 8'h00, 0, 0, 0, 0);

    // R10 size change during a character
    mark();
    fork
      send_char(8'hC3, 8, 0, 0, 1, 0, 16);
      begin repeat (40 * TDIV) @(negedge clk); cfg_size = 4'd7; end
    join
    expect_evt("R10 captured size", 1, 8'hC3, 0, 0, 0, 0);
    cfg_size = 4'd8;

    finish_run();
  end
endmodule